// File: doc/BRIEF.md
# Grouped Interrupt Status Controller

This block gathers the event pulses of a serial-bus link-layer controller (packet received and verified, cycle done, cycle lost, arbitration lost and the like) into sticky status bits. It qualifies them with per-bit enables and drives one registered interrupt line to the host. Three banks hold the bits: two primary banks (A and B) and one extended bank (X). Software clears a status bit by writing 1 to its position. The extended bank also carries two read-only group summary flags, so the host can read X alone to learn whether anything needs attention.

A diagnostic access bit turns the status banks into plainly writable registers, which lets software force interrupt paths without real traffic. The summary flag for banks A/B is never writable. The summary flag for bank X is not stored anywhere: it is always recomputed from the event bits of bank X.

All control and status pins are plain level signals. There is no streaming data path. Register reads are combinational from the current state. Writes take effect at the clock edge on which `bus_we` is high.

Top module: `irq_status_ctrl`

## Requirements
- R1: A 1 on an implemented bit of `evt_a`, `evt_b` or `evt_x` at a clock edge sets the matching status bit. The bit stays 1 until it is cleared. Register map: 0 = bank A status, 1 = bank A enable, 2 = bank B status, 3 = bank B enable, 4 = bank X status, 5 = bank X enable, 6 = diagnostic control, 7 = unmapped.
- R2: With diagnostic access off, writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R3: When an event and a clearing write hit the same bit in the same cycle, the bit ends up 1.
- R4: Bit 1 of bank X status reads as the OR of every bank A and bank B status bit. Writes to bit 1 never change it.
- R5: Bit 2 of bank X status reads as the OR of the bank X event bits, which are bits 3, 4 and 6 by default. Software cannot clear bit 2 directly.
- R6: Bit 0 of register 6 is the diagnostic access flag. While it is 1, a write to a status register loads the written value into its implemented event bits (ORed with any same-cycle event). Bit 1 still follows R4, and bit 2 is still recomputed as in R5.
- R7: `irq` is registered. It is 1 in the cycle after any status bit and its enable bit are both 1, and 0 in the cycle after no such pair exists.
- R8: Enable registers read back what was written, restricted to the implemented bits of their bank. Bank X enables exist only for its event bits.
- R9: Unimplemented bits (bank X bits 0, 5 and 7 by default), the upper bits of register 6 and the whole of address 7 read 0 and ignore writes.
- R10: `rst_n` low clears all status, enables, the diagnostic flag and `irq`. A `sw_rst` pulse clears all status bits and leaves the enables in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Synchronous clear of all status bits |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` |
| evt_a | input | 8 | Event pulses for bank A |
| evt_b | input | 8 | Event pulses for bank B |
| evt_x | input | 8 | Event pulses for bank X (only implemented bits used) |
| irq | output | 1 | Host interrupt |

## Verification
The assertions assume that `bus_we`, `bus_addr`, `bus_wdata`, `sw_rst` and the event inputs are known values at every clock edge after reset. They also assume that a `sw_rst` cycle overrides any write in the same cycle, so the write and clear properties are disabled while `sw_rst` is high. The stimulus drives every input to a defined level from time zero and changes inputs only a nanosecond after a rising edge. It never raises `sw_rst` together with a write.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int NB = 3;
  localparam int SUM_GRP0_BIT = 1;
  localparam int SUM_GRP1_BIT = 2;

  typedef enum logic [AW-1:0] {
    ADR_STAT_A = 3'd0,
    ADR_EN_A   = 3'd1,
    ADR_STAT_B = 3'd2,
    ADR_EN_B   = 3'd3,
    ADR_STAT_X = 3'd4,
    ADR_EN_X   = 3'd5,
    ADR_DIAG   = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int W = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_rst,
  input  logic         diag,
  input  logic         wr_stat,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] evt,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] en_q
);
  logic [W-1:0] evt_m;
  logic [W-1:0] wd_m;
  logic [W-1:0] stat_d;

  assign evt_m = evt & MASK;
  assign wd_m  = wdata & MASK;

  always_comb begin
    if (sw_rst)
      stat_d = '0;
    else if (wr_stat && diag)
      stat_d = wd_m | evt_m;
    else if (wr_stat)
      stat_d = (stat_q & ~wd_m) | evt_m;
    else
      stat_d = stat_q | evt_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= stat_d;
      if (wr_en)
        en_q <= wd_m;
    end
  end

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_m != '0) && !sw_rst) |=> ((stat_q & $past(evt_m)) == $past(evt_m))); // R1
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !diag && !sw_rst) |=> ((stat_q & $past(wdata & ~evt & MASK)) == '0)); // R2
  AST_W0_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !diag && !sw_rst && ((wdata & MASK) == '0)) |=> (stat_q == $past(stat_q | evt_m))); // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !sw_rst && ((wdata & evt & MASK) != '0)) |=> ((stat_q & $past(wdata & evt & MASK)) != '0)); // R3
  AST_DIAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && diag && !sw_rst && ((wdata & MASK) == '0) && (evt_m == '0)) |=> (stat_q == '0)); // R6
  AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (stat_q == '0)); // R10
  AST_EN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !sw_rst) |=> $stable(en_q)); // R10
  AST_UNIMPL: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~MASK) == '0) && ((en_q & ~MASK) == '0)); // R9
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int NB = 3,
  parameter int DW = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NB-1:0][DW-1:0]  stat,
  input  logic [NB-1:0][DW-1:0]  en,
  output logic                   grp0,
  output logic                   grp1,
  output logic                   irq
);
  logic [NB-1:0] hit;
  logic [NB-1:0] nz;

  for (genvar g = 0; g < NB; g++) begin : g_bank
    assign hit[g] = |(stat[g] & en[g]);
    assign nz[g]  = |stat[g];
  end

  assign grp0 = |nz[NB-2:0];
  assign grp1 = nz[NB-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      irq <= 1'b0;
    else
      irq <= |hit;
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter logic [DW-1:0] A_MASK = '1,
  parameter logic [DW-1:0] B_MASK = '1,
  parameter logic [DW-1:0] X_MASK = 8'h58
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_rst,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] evt_a,
  input  logic [DW-1:0] evt_b,
  input  logic [DW-1:0] evt_x,
  output logic          irq
);
  localparam logic [NB-1:0][DW-1:0] BANK_MASK = {X_MASK, B_MASK, A_MASK};
  localparam logic [DW-1:0] SUM_MASK = DW'((1 << SUM_GRP0_BIT) | (1 << SUM_GRP1_BIT));

  logic [NB-1:0][DW-1:0] st_w;
  logic [NB-1:0][DW-1:0] en_w;
  logic [NB-1:0][DW-1:0] evt_w;
  logic                  grp0;
  logic                  grp1;
  logic                  diag_q;
  logic [DW-1:0]         sum_bits;

  assign evt_w = {evt_x, evt_b, evt_a};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      diag_q <= 1'b0;
    else if (bus_we && (bus_addr == ADR_DIAG))
      diag_q <= bus_wdata[0];
  end

  for (genvar g = 0; g < NB; g++) begin : g_bank
    irq_bank #(
      .W    (DW),
      .MASK (BANK_MASK[g])
    ) i_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .sw_rst  (sw_rst),
      .diag    (diag_q),
      .wr_stat (bus_we && (bus_addr == AW'(2*g))),
      .wr_en   (bus_we && (bus_addr == AW'(2*g+1))),
      .wdata   (bus_wdata),
      .evt     (evt_w[g]),
      .stat_q  (st_w[g]),
      .en_q    (en_w[g])
    );
  end

  irq_merge #(
    .NB (NB),
    .DW (DW)
  ) i_merge (
    .clk   (clk),
    .rst_n (rst_n),
    .stat  (st_w),
    .en    (en_w),
    .grp0  (grp0),
    .grp1  (grp1),
    .irq   (irq)
  );

  always_comb begin
    sum_bits = '0;
    sum_bits[SUM_GRP0_BIT] = grp0;
    sum_bits[SUM_GRP1_BIT] = grp1;
  end

  always_comb begin
    case (reg_addr_e'(bus_addr))
      ADR_STAT_A: bus_rdata = st_w[0];
      ADR_EN_A:   bus_rdata = en_w[0];
      ADR_STAT_B: bus_rdata = st_w[1];
      ADR_EN_B:   bus_rdata = en_w[1];
      ADR_STAT_X: bus_rdata = st_w[2] | sum_bits;
      ADR_EN_X:   bus_rdata = en_w[2];
      ADR_DIAG:   bus_rdata = {{(DW-1){1'b0}}, diag_q};
      default:    bus_rdata = '0;
    endcase
  end

  AST_GRP0_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADR_STAT_X) |-> (bus_rdata[SUM_GRP0_BIT] == ((st_w[0] != '0) || (st_w[1] != '0)))); // R4
  AST_GRP1_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADR_STAT_X) |-> (bus_rdata[SUM_GRP1_BIT] == ((bus_rdata & X_MASK) != '0))); // R5
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (((st_w[0] & en_w[0]) != '0) || ((st_w[1] & en_w[1]) != '0) || ((st_w[2] & en_w[2]) != '0)) |=> irq); // R7
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (((st_w[0] & en_w[0]) == '0) && ((st_w[1] & en_w[1]) == '0) && ((st_w[2] & en_w[2]) == '0)) |=> !irq); // R7
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADR_STAT_X) |-> ((bus_rdata & ~(X_MASK | SUM_MASK)) == '0)); // R9
  AST_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd7) |-> (bus_rdata == '0)); // R9
endmodule

// File: tb/test_irq_status_ctrl.sv
`timescale 1ns/1ps
module test_irq_status_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sw_rst = 1'b0;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] evt_a = 8'h00;
  logic [7:0] evt_b = 8'h00;
  logic [7:0] evt_x = 8'h00;
  logic       irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_status_ctrl i_irq_status_ctrl (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_a(evt_a), .evt_b(evt_b), .evt_x(evt_x), .irq(irq)
  );

  typedef struct packed {
    logic       we;
    logic [2:0] wa;
    logic [7:0] wd;
    logic [7:0] ea;
    logic [7:0] eb;
    logic [7:0] ex;
    logic [2:0] ra;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 3'd0, 8'h00, 8'h05, 8'h00, 8'h00, 3'd0, 8'h05}, // R1 set A
    '{1'b0, 3'd0, 8'h00, 8'h00, 8'h00, 8'h00, 3'd4, 8'h02}, // R4 group flag
    '{1'b1, 3'd0, 8'h01, 8'h00, 8'h00, 8'h00, 3'd0, 8'h04}, // R2 clear
    '{1'b1, 3'd0, 8'h00, 8'h00, 8'h00, 8'h00, 3'd0, 8'h04}, // R2 write 0
    '{1'b0, 3'd0, 8'h00, 8'h00, 8'h00, 8'hFF, 3'd4, 8'h5E}, // R5 R9 X events
    '{1'b1, 3'd4, 8'hFF, 8'h00, 8'h00, 8'h00, 3'd4, 8'h02}, // R4 R5 clear X
    '{1'b1, 3'd0, 8'h04, 8'h00, 8'h00, 8'h00, 3'd4, 8'h00}, // R4 flag drops
    '{1'b0, 3'd0, 8'h00, 8'h00, 8'h80, 8'h00, 3'd4, 8'h02}, // R4 via B
    '{1'b1, 3'd2, 8'h80, 8'h00, 8'h80, 8'h00, 3'd2, 8'h80}, // R3 set wins
    '{1'b1, 3'd2, 8'h80, 8'h00, 8'h00, 8'h00, 3'd2, 8'h00}, // R2 clear B
    '{1'b1, 3'd1, 8'hAA, 8'h00, 8'h00, 8'h00, 3'd1, 8'hAA}, // R8 enable A
    '{1'b1, 3'd5, 8'hFF, 8'h00, 8'h00, 8'h00, 3'd5, 8'h58}, // R8 enable X
    '{1'b1, 3'd6, 8'hFF, 8'h00, 8'h00, 8'h00, 3'd6, 8'h01}, // R6 R9 diag on
    '{1'b1, 3'd4, 8'hFF, 8'h00, 8'h00, 8'h00, 3'd4, 8'h5C}, // R6 direct X
    '{1'b1, 3'd4, 8'h04, 8'h00, 8'h00, 8'h00, 3'd4, 8'h00}, // R6 bit2 recomputed
    '{1'b1, 3'd0, 8'h30, 8'h00, 8'h00, 8'h00, 3'd0, 8'h30}, // R6 direct A
    '{1'b0, 3'd0, 8'h00, 8'h00, 8'h00, 8'h00, 3'd4, 8'h02}, // R6 bit1 follows
    '{1'b1, 3'd0, 8'h00, 8'h00, 8'h00, 8'h00, 3'd0, 8'h00}, // R6 direct zero
    '{1'b1, 3'd6, 8'h00, 8'h00, 8'h00, 8'h00, 3'd6, 8'h00}, // R6 diag off
    '{1'b1, 3'd7, 8'hFF, 8'h00, 8'h00, 8'h00, 3'd7, 8'h00}  // R9 unmapped
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic edge1();
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    edge1();
    bus_we = 1'b0; bus_wdata = 8'h00;
  endtask

  initial begin
    #1_600_000;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) rd(3'(a), 8'h00, "R10 reset value");
    check("R10 reset irq", {7'b0, irq}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      bus_we = VEC[i].we; bus_addr = VEC[i].wa; bus_wdata = VEC[i].wd;
      evt_a = VEC[i].ea; evt_b = VEC[i].eb; evt_x = VEC[i].ex;
      edge1();
      bus_we = 1'b0; bus_wdata = 8'h00;
      evt_a = 8'h00; evt_b = 8'h00; evt_x = 8'h00;
      rd(VEC[i].ra, VEC[i].exp, $sformatf("R%0d vector %0d", 0, i));
    end

    // R7: enable A = AA, enable X = 58, all status clear
    evt_a = 8'h01; edge1(); evt_a = 8'h00;
    edge1();
    check("R7 disabled bit no irq", {7'b0, irq}, 8'h00);
    evt_a = 8'h02; edge1(); evt_a = 8'h00;
    check("R7 irq one cycle later", {7'b0, irq}, 8'h00);
    edge1();
    check("R7 irq asserted", {7'b0, irq}, 8'h01);
    wr(3'd0, 8'h03);
    check("R7 irq still high after clear edge", {7'b0, irq}, 8'h01);
    edge1();
    check("R7 irq deasserted", {7'b0, irq}, 8'h00);
    evt_x = 8'h08; edge1(); evt_x = 8'h00;
    edge1();
    check("R7 irq from bank X", {7'b0, irq}, 8'h01);
    rd(3'd4, 8'h0C, "R5 X flag with event");

    // R10: software reset
    evt_b = 8'h11; edge1(); evt_b = 8'h00;
    sw_rst = 1'b1; edge1(); sw_rst = 1'b0;
    rd(3'd4, 8'h00, "R10 sw_rst clears X");
    rd(3'd2, 8'h00, "R10 sw_rst clears B");
    rd(3'd1, 8'hAA, "R10 sw_rst keeps enable");
    edge1();
    check("R10 irq after sw_rst", {7'b0, irq}, 8'h00);

    // R9: ignored writes to unmapped address observed via all registers
    wr(3'd7, 8'hFF);
    rd(3'd0, 8'h00, "R9 unmapped write A");
    rd(3'd6, 8'h00, "R9 unmapped write diag");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule